// File: doc/BRIEF.md
# Key-Locked Reset Watchdog

This block is a countdown watchdog for a power-management device. Software programs a 32-bit timeout as two 16-bit halves, sets the control bits, and the counter then decrements once per pulse of a 32.768 kHz tick strobe. When the count runs out and both arming bits are set, the block drives a system reset pulse of fixed length and records the event in a sticky flag. At the tick rate, a timeout of 50 ms corresponds to a load of roughly 1638.

The register file is write-protected. Writing the 16-bit key 0xE551 to the lock register opens the load and control registers for writing. Writing the bitwise complement of the key, 0x1AAE, closes them again. The watchdog counts only while two enable inputs are both high: a module-enable and a clock-enable, which are held in registers outside this block. Register writes arrive over a simple write strobe, address and data. Reads are combinational from the address.

Top module: `lockwd_top`

## Requirements
- R1: After rstN is released, the block is locked, lock reads 1, load halves and control read 0, and wdRst and expired are 0.
- R2: Writing 0xE551 to the lock register (offset 0x20) unlocks the block. Writing 0x1AAE locks it. Any other value leaves the lock state unchanged. Bit 0 of a lock-register read is 1 while locked and 0 while unlocked.
- R3: While locked, writes to offsets 0x0, 0x4 and 0x8 leave those registers unchanged.
- R4: Control is at offset 0x8. Bit 1 is run, bit 2 is new-mode and bit 3 is reset-enable. All other bits are not stored and read as 0.
- R5: A write to the high half (offset 0x4) is staged. It takes effect, together with the low half, when offset 0x0 is written. Reads of 0x0 and 0x4 return the active load halves.
- R6: Writing run from 0 to 1 reloads the counter from the full 32-bit load. Writing run=1 while run is already 1 does not reload.
- R7: The counter decrements on a tick only when run, modEn and clkEn are all 1. Otherwise it holds its value.
- R8: A counted tick that finds the count at 0 or 1 is an expiry, and the counter reloads from the load value. A load of N gives expiry on the N-th tick (on the first tick for N of 0 or 1).
- R9: An expiry with new-mode and reset-enable both set drives wdRst high for RST_CYCLES clocks, starting the clock after the tick edge. An expiry with either bit clear drives no pulse. An expiry during a pulse does not extend it.
- R10: expired goes to 1 with the first reset pulse and stays 1 until rstN.
- R11: Reads of any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset for read and write |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for addr |
| tick | input | 1 | One-clock pulse at the 32.768 kHz rate |
| modEn | input | 1 | Module-enable bit from the external register |
| clkEn | input | 1 | Clock-enable bit from the external register |
| wdRst | output | 1 | System reset pulse |
| expired | output | 1 | Sticky flag for a reset expiry |

## Verification
The assertions check the following on every clock:
- the lock holds unless the exact key arrives, and the key always opens it;
- run never moves while the block is locked;
- a reset pulse only rises after a tick that was counted with run, modEn and clkEn all high;
- the pulse is exactly RST_CYCLES long and always has the sticky flag behind it.

Other behaviour only the bench scenarios can show:
- how the load halves are staged;
- that a repeated run write does not reload the counter;
- that the count holds across a disabled interval;
- the exact tick on which expiry lands for loads of 3 and 0;
- that an incomplete arming expires silently.

// File: rtl/lockwd_pkg.sv
package lockwd_pkg;
  localparam logic [15:0] UNLOCK_KEY = 16'hE551;
  localparam logic [15:0] RELOCK_KEY = ~UNLOCK_KEY;

  localparam int OFS_LOAD_LO = 'h00;
  localparam int OFS_LOAD_HI = 'h04;
  localparam int OFS_CTRL    = 'h08;
  localparam int OFS_LOCK    = 'h20;

  localparam int BIT_RUN   = 1;
  localparam int BIT_NEW   = 2;
  localparam int BIT_RSTEN = 3;

  typedef struct packed {
    logic reload;   // run written 0 -> 1
    logic countEn;  // tick with run and both enables
    logic rstArm;   // new-mode and reset-enable both set
  } dpStrobe_t;
endpackage

// File: rtl/lockwd_ctrl.sv
module lockwd_ctrl
  import lockwd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tick,
  input  logic              modEn,
  input  logic              clkEn,
  output logic [DATA_W-1:0] rdData,
  output dpStrobe_t         strb,
  output logic [CNT_W-1:0]  loadVal,
  output logic              lockedQ,
  output logic              runQ
);
  logic [DATA_W-1:0] loHalf, hiHalf, hiStage;
  logic newModeQ, rstEnQ;
  logic hitLo, hitHi, hitCtl, hitLock, wrOpen;

  assign hitLo   = (addr == ADDR_W'(OFS_LOAD_LO));
  assign hitHi   = (addr == ADDR_W'(OFS_LOAD_HI));
  assign hitCtl  = (addr == ADDR_W'(OFS_CTRL));
  assign hitLock = (addr == ADDR_W'(OFS_LOCK));
  assign wrOpen  = wrEn && !lockedQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockedQ  <= 1'b1;
      loHalf   <= '0;
      hiHalf   <= '0;
      hiStage  <= '0;
      runQ     <= 1'b0;
      newModeQ <= 1'b0;
      rstEnQ   <= 1'b0;
    end else begin
      if (wrEn && hitLock) begin
        if (wrData == DATA_W'(UNLOCK_KEY))      lockedQ <= 1'b0;
        else if (wrData == DATA_W'(RELOCK_KEY)) lockedQ <= 1'b1;
      end
      if (wrOpen && hitHi) hiStage <= wrData;
      if (wrOpen && hitLo) begin
        loHalf <= wrData;
        hiHalf <= hiStage;
      end
      if (wrOpen && hitCtl) begin
        runQ     <= wrData[BIT_RUN];
        newModeQ <= wrData[BIT_NEW];
        rstEnQ   <= wrData[BIT_RSTEN];
      end
    end
  end

  always_comb begin
    strb.reload  = wrOpen && hitCtl && wrData[BIT_RUN] && !runQ;
    strb.countEn = tick && runQ && modEn && clkEn;
    strb.rstArm  = newModeQ && rstEnQ;
  end

  assign loadVal = {hiHalf, loHalf};

  always_comb begin
    rdData = '0;
    if (hitLo)   rdData = loHalf;
    if (hitHi)   rdData = hiHalf;
    if (hitCtl) begin
      rdData[BIT_RUN]   = runQ;
      rdData[BIT_NEW]   = newModeQ;
      rdData[BIT_RSTEN] = rstEnQ;
    end
    if (hitLock) rdData[0] = lockedQ;
  end
endmodule

// File: rtl/lockwd_dp.sv
module lockwd_dp
  import lockwd_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int RST_CYCLES = 8,
  localparam int PULSE_W   = $clog2(RST_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [CNT_W-1:0] loadVal,
  output logic             wdRst,
  output logic             expired
);
  logic [CNT_W-1:0]   countQ;
  logic [PULSE_W-1:0] pulseQ;
  logic expire, fire;

  assign expire = strb.countEn && !strb.reload && (countQ <= CNT_W'(1));
  assign fire   = expire && strb.rstArm && (pulseQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ  <= '0;
      pulseQ  <= '0;
      expired <= 1'b0;
    end else begin
      if (strb.reload)       countQ <= loadVal;
      else if (expire)       countQ <= loadVal;
      else if (strb.countEn) countQ <= countQ - CNT_W'(1);

      if (fire)                pulseQ <= PULSE_W'(RST_CYCLES);
      else if (pulseQ != '0)   pulseQ <= pulseQ - PULSE_W'(1);

      if (fire) expired <= 1'b1;
    end
  end

  assign wdRst = (pulseQ != '0);
endmodule

// File: rtl/lockwd_top.sv
module lockwd_top
  import lockwd_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 6,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              tick,
  input  logic              modEn,
  input  logic              clkEn,
  output logic              wdRst,
  output logic              expired
);
  localparam int CNT_W = 2 * DATA_W;

  dpStrobe_t        strb;
  logic [CNT_W-1:0] loadVal;
  logic             lockedQ, runQ;

  lockwd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .tick(tick), .modEn(modEn), .clkEn(clkEn), .rdData(rdData),
    .strb(strb), .loadVal(loadVal), .lockedQ(lockedQ), .runQ(runQ)
  );

  lockwd_dp #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(loadVal),
    .wdRst(wdRst), .expired(expired)
  );
endmodule

// File: rtl/lockwd_chk.sv
module lockwd_chk
  import lockwd_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 6,
  parameter int RST_CYCLES = 8,
  localparam int HW        = $clog2(RST_CYCLES + 2)
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic              tick,
  input logic              modEn,
  input logic              clkEn,
  input logic              wdRst,
  input logic              expired,
  input logic              lockedQ,
  input logic              runQ
);
  logic [HW-1:0] hiCnt;
  logic keyHit;

  assign keyHit = wrEn && (addr == ADDR_W'(OFS_LOCK)) && (wrData == DATA_W'(UNLOCK_KEY));

  always_ff @(posedge clk) begin
    if (!rstN)      hiCnt <= '0;
    else if (wdRst) hiCnt <= hiCnt + HW'(1);
    else            hiCnt <= '0;
  end

  // R2
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockedQ && !keyHit |=> lockedQ);

  // R2
  unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    keyHit |=> !lockedQ);

  // R3
  locked_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockedQ |=> $stable(runQ));

  // R7
  rst_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdRst) |-> $past(tick && modEn && clkEn && runQ));

  // R9
  pulse_max_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdRst |-> hiCnt < HW'(RST_CYCLES));

  // R9
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wdRst) |-> $past(hiCnt) == HW'(RST_CYCLES - 1));

  // R10
  flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdRst |-> expired);

  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    expired |=> expired);
endmodule

bind lockwd_top lockwd_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .tick(tick), .modEn(modEn), .clkEn(clkEn), .wdRst(wdRst),
  .expired(expired), .lockedQ(lockedQ), .runQ(runQ)
);

// File: tb/lockwd_top_tb.sv
module lockwd_top_tb;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 6;
  localparam int RSTC   = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic tick = 1'b0, modEn = 1'b0, clkEn = 1'b0;
  logic wdRst, expired;

  int nChk = 0, nFail = 0, cyc = 0;
  bit done = 1'b0;
  int expStart[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lockwd_top #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RST_CYCLES(RSTC)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .tick(tick), .modEn(modEn), .clkEn(clkEn),
    .wdRst(wdRst), .expired(expired)
  );

  task automatic chk(input int act, input int exp, input string req);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; addr = ADDR_W'(a); wrData = DATA_W'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string req);
    @(negedge clk);
    addr = ADDR_W'(a);
    #1 chk(int'(rdData), exp, req);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: one tick; when a pulse is expected its start cycle goes to the scoreboard
  task automatic tickOnce(input bit expectPulse);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    if (expectPulse) expStart.push_back(cyc);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tickOnce(1'b0);
  endtask

  // monitor: measures each reset pulse and compares with the queue
  initial begin
    logic prev = 1'b0;
    int startCyc = 0, hiLen = 0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (wdRst && !prev) begin
          startCyc = cyc;
          hiLen = 1;
        end else if (wdRst) begin
          hiLen++;
        end else if (prev) begin
          if (expStart.size() == 0) begin
            nChk++; nFail++;
            $display("FAIL R9: actual pulse at cycle %0d expected none", startCyc);
          end else begin
            int e;
            e = expStart.pop_front();
            chk(startCyc, e, "R8 pulse start cycle");
            chk(hiLen, RSTC, "R9 pulse width");
          end
        end
        prev = wdRst;
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    // R1 reset state
    rd('h00, 0, "R1 load lo"); rd('h04, 0, "R1 load hi");
    rd('h08, 0, "R1 ctrl");    rd('h20, 1, "R1 lock");
    chk(int'(wdRst), 0, "R1 wdRst"); chk(int'(expired), 0, "R1 expired");

    // R3 locked writes ignored
    wr('h08, 'hE); wr('h04, 5); wr('h00, 7);
    rd('h08, 0, "R3 ctrl locked"); rd('h00, 0, "R3 lo locked"); rd('h04, 0, "R3 hi locked");

    // R2 wrong key, then key
    wr('h20, 'h1234); rd('h20, 1, "R2 wrong key");
    wr('h20, 'hE551); rd('h20, 0, "R2 unlock");

    // R5 staging of the high half
    wr('h04, 1); rd('h04, 0, "R5 hi staged");
    wr('h00, 3); rd('h00, 3, "R5 lo"); rd('h04, 1, "R5 hi committed");
    wr('h04, 0); wr('h00, 3); rd('h04, 0, "R5 hi zero");

    // R2 relock, R3 ignored
    wr('h20, 'h1AAE); rd('h20, 1, "R2 relock");
    wr('h08, 'hE); rd('h08, 0, "R3 ctrl relocked");
    wr('h20, 'hE551);

    // R4 field masking
    wr('h08, 'hFFF5); rd('h08, 'h4, "R4 ctrl mask");
    wr('h08, 0);

    modEn = 1'b1; clkEn = 1'b1;
    // R6 reload to 3, R8 third tick expires, R9 pulse
    wr('h08, 'hE);
    tickOnce(0); tickOnce(0); tickOnce(1); idle(RSTC + 3);
    chk(int'(expired), 1, "R10 expired set");
    rd('h08, 'hE, "R4 ctrl readback");

    // R8 reload after expiry
    tickOnce(0); tickOnce(0); tickOnce(1); idle(RSTC + 3);

    // R6 rewrite with run already set does not reload
    tickOnce(0); wr('h08, 'hE); tickOnce(0); tickOnce(1); idle(RSTC + 3);

    // R7 enables hold the count
    tickOnce(0);
    clkEn = 1'b0; ticks(3); clkEn = 1'b1;
    modEn = 1'b0; ticks(3); modEn = 1'b1;
    tickOnce(0); tickOnce(1); idle(RSTC + 3);

    // R7 run cleared holds
    wr('h08, 'hC); ticks(4);

    // R9 incomplete arming: silent expiry
    wr('h08, 'hA); ticks(3);
    wr('h08, 'h6); ticks(3);
    idle(RSTC);
    chk(int'(wdRst), 0, "R9 no pulse when unarmed");
    chk(int'(expired), 1, "R10 expired sticky");

    // R8 load zero expires on first tick; R9 expiry in pulse does not extend it
    wr('h08, 0); wr('h00, 0); wr('h08, 'hE);
    tickOnce(1); tickOnce(0); idle(RSTC + 3);

    // R11 unmapped reads
    rd('h10, 0, "R11 unmapped 0x10"); rd('h0C, 0, "R11 unmapped 0x0C");

    idle(RSTC + 4);
    chk(expStart.size(), 0, "R9 all expected pulses seen");
    chk(int'(expired), 1, "R10 expired final");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule